// File: doc/BRIEF.md
# Four-Bank Concurrent Access Router

This block keeps track of which bank of a four-bank memory is tied up by a long program or erase job, so that reads can keep flowing to every other bank. Each address carries a three-bit region code in its top bits. The code maps unevenly onto the banks: the two small banks each own one code, and the two large banks own three codes each. A job engine outside the block receives accepted start requests and answers with a one-cycle completion pulse. The block itself does not decode command sequences and holds no array data.

For every read, the block reports in the same cycle which bank the address falls in. It also reports whether the reply must come from the status path, because that bank is running the job, or from the array path. Moving a read from the busy bank to an idle bank costs no wait cycles. Only one job may run in the whole device at a time. A start request that arrives while a job runs is refused with an error flag and changes no state. A ready output is 1 when no job runs and 0 while one does.

The controller has two states. `ST_ARRAY_READ` means every bank serves array data. `ST_JOB_ACTIVE` means one recorded bank serves status. The transition `T_ACCEPT` goes from `ST_ARRAY_READ` to `ST_JOB_ACTIVE` on a start request and records the decoded bank. The transition `T_FINISH` goes from `ST_JOB_ACTIVE` back to `ST_ARRAY_READ` on a completion pulse. `T_REFUSE` keeps `ST_JOB_ACTIVE` when a start request arrives without a completion pulse. `T_HOLD` covers every other case and leaves the state unchanged.

Top module: `bank_concurrency_router`

## Requirements
- R1: The region code is address bits [21:19]. Code 0 selects bank index 0. Codes 1 to 3 select bank index 1. Codes 4 to 6 select bank index 2. Code 7 selects bank index 3. `rd_bank` reports the index for `rd_addr` in the same cycle.
- R2: After reset, `ready` is 1, `bank_busy` is 0000, and neither `start_err` nor `rd_status` is asserted.
- R3: When no job runs, `start_vld` is accepted. From the next cycle, `ready` is 0 and `bank_busy` has exactly the bit of the decoded start bank set (bit n for bank index n).
- R4: While a job runs, `start_vld` raises `start_err` in that same cycle, and the busy bank does not change.
- R5: A read (`rd_vld`=1) to any code of the bank running the job gives `rd_status`=1 in the same cycle.
- R6: A read to any other bank, or any read while no job runs, gives `rd_status`=0 in the same cycle. This holds even on the cycle right after a read of the busy bank.
- R7: A `done_pulse` while a job runs makes `ready` 1 and `bank_busy` 0000 on the next cycle. If a start request arrives in the same cycle, it is refused with `start_err`.
- R8: A `done_pulse` while no job runs has no effect: `ready` stays 1 and `bank_busy` stays 0000. When it arrives together with a start request, the request is accepted as in R3.
- R9: `bank_busy` never has more than one bit set, and `ready` is 1 exactly when `bank_busy` is 0000.
- R10: When a large bank runs a job, all three of its codes read as status, and the codes of the other large bank read as array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_vld | input | 1 | Request to start a program/erase job |
| start_addr | input | 22 | Address of the job; its top three bits pick the bank |
| done_pulse | input | 1 | One-cycle completion pulse from the job engine |
| rd_vld | input | 1 | A read is presented this cycle |
| rd_addr | input | 22 | Read address |
| rd_status | output | 1 | 1: reply with status word, 0: reply with array data |
| rd_bank | output | 2 | Bank index decoded from rd_addr |
| start_err | output | 1 | Start request refused because a job runs |
| ready | output | 1 | 1 when idle, 0 while a job runs |
| bank_busy | output | 4 | One bit per bank, set for the bank running a job |

## Verification
The assertions assume that `done_pulse` only carries meaning while a job runs, and that the inputs are at known values once reset is released. They do not assume that the engine pulses only once per job, because a stray pulse while idle is a case the block must ignore. The stimulus changes every input just after the falling edge and holds it for a full cycle. It sends completion pulses both during jobs and while idle, including cycles where a pulse and a start request arrive together, so that both readings of R7 and R8 are covered.

// File: rtl/bank_router_pkg.sv
package bank_router_pkg;

    localparam int NUM_BANKS  = 4;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int CODE_W     = 3;

    typedef logic [BANK_IDX_W-1:0] bank_idx_t;
    typedef logic [CODE_W-1:0]     region_code_t;

    typedef enum logic [0:0] {
        ST_ARRAY_READ = 1'b0,
        ST_JOB_ACTIVE = 1'b1
    } job_state_e;

endpackage

// File: rtl/bank_code_decoder.sv
module bank_code_decoder
    import bank_router_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter bit UNEVEN = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_idx_t         bank
);

    localparam int CODE_LSB = ADDR_W - CODE_W;

    region_code_t code;
    assign code = addr[ADDR_W-1:CODE_LSB];

    generate
        if (UNEVEN) begin : g_uneven
            // all-zero and all-one codes own the two small banks
            always_comb begin
                if (code == '0) begin
                    bank = bank_idx_t'(0);
                end else if (code == '1) begin
                    bank = bank_idx_t'(NUM_BANKS - 1);
                end else if (code[CODE_W-1] == 1'b0) begin
                    bank = bank_idx_t'(1);
                end else begin
                    bank = bank_idx_t'(2);
                end
            end
        end else begin : g_even
            always_comb begin
                bank = code[CODE_W-1 -: BANK_IDX_W];
            end
        end
    endgenerate

endmodule

// File: rtl/job_tracker.sv
module job_tracker
    import bank_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_vld,
    input  bank_idx_t            start_bank,
    input  logic                 done_pulse,
    output logic                 job_active,
    output bank_idx_t            job_bank,
    output logic                 start_err,
    output logic [NUM_BANKS-1:0] bank_busy
);

    job_state_e state_q, state_d;
    bank_idx_t  bank_q, bank_d;

    // next-state logic, transitions named T_ACCEPT / T_FINISH / T_REFUSE / T_HOLD
    always_comb begin
        state_d = state_q;
        bank_d  = bank_q;
        unique case (state_q)
            ST_ARRAY_READ: begin
                if (start_vld) begin
                    state_d = ST_JOB_ACTIVE;   // T_ACCEPT
                    bank_d  = start_bank;
                end
            end
            ST_JOB_ACTIVE: begin
                if (done_pulse) begin
                    state_d = ST_ARRAY_READ;   // T_FINISH
                end
            end
            default: state_d = ST_ARRAY_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARRAY_READ;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
        end
    end

    // outputs
    always_comb begin
        job_active = 1'b0;
        start_err  = 1'b0;
        bank_busy  = '0;
        unique case (state_q)
            ST_ARRAY_READ: begin
                job_active = 1'b0;
            end
            ST_JOB_ACTIVE: begin
                job_active        = 1'b1;
                start_err         = start_vld;   // T_REFUSE
                bank_busy[bank_q] = 1'b1;
            end
            default: job_active = 1'b0;
        endcase
    end

    assign job_bank = bank_q;

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!job_active && start_vld) |=> (job_active && job_bank == $past(start_bank)));

    p_refuse_keeps_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (job_active && start_vld && !done_pulse) |=> (job_active && $stable(job_bank)));

    p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (job_active && done_pulse) |=> (!job_active && bank_busy == '0));

    p_idle_done_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!job_active && done_pulse && !start_vld) |=> !job_active);

    p_single_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_busy));

endmodule

// File: rtl/read_steer.sv
module read_steer
    import bank_router_pkg::*;
(
    input  logic                 rd_vld,
    input  bank_idx_t            rd_bank,
    input  logic [NUM_BANKS-1:0] bank_busy,
    output logic                 rd_status
);

    logic [NUM_BANKS-1:0] hit;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign hit[b] = rd_vld && (rd_bank == bank_idx_t'(b)) && bank_busy[b];
        end
    endgenerate

    assign rd_status = |hit;

endmodule

// File: rtl/bank_concurrency_router.sv
module bank_concurrency_router
    import bank_router_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              done_pulse,
    input  logic              rd_vld,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_status,
    output logic [1:0]        rd_bank,
    output logic              start_err,
    output logic              ready,
    output logic [3:0]        bank_busy
);

    bank_idx_t            start_bank;
    bank_idx_t            read_bank;
    bank_idx_t            job_bank;
    logic                 job_active;
    logic [NUM_BANKS-1:0] busy_vec;

    bank_code_decoder #(.ADDR_W(ADDR_W), .UNEVEN(1'b1)) u_start_dec (
        .addr (start_addr),
        .bank (start_bank)
    );

    bank_code_decoder #(.ADDR_W(ADDR_W), .UNEVEN(1'b1)) u_read_dec (
        .addr (rd_addr),
        .bank (read_bank)
    );

    job_tracker u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_vld  (start_vld),
        .start_bank (start_bank),
        .done_pulse (done_pulse),
        .job_active (job_active),
        .job_bank   (job_bank),
        .start_err  (start_err),
        .bank_busy  (busy_vec)
    );

    read_steer u_steer (
        .rd_vld    (rd_vld),
        .rd_bank   (read_bank),
        .bank_busy (busy_vec),
        .rd_status (rd_status)
    );

    assign rd_bank   = read_bank;
    assign ready     = !job_active;
    assign bank_busy = busy_vec;

    p_status_on_job_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && job_active && read_bank == job_bank) |-> rd_status);

    p_array_elsewhere_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && (!job_active || read_bank != job_bank)) |-> !rd_status);

    p_ready_matches_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (bank_busy == 4'b0000));

endmodule

// File: tb/bank_concurrency_router_bench.sv
module bank_concurrency_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_vld = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          done_pulse = 1'b0;
    logic          rd_vld = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_status;
    logic [1:0]    rd_bank;
    logic          start_err;
    logic          ready;
    logic [3:0]    bank_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_concurrency_router u_bank_concurrency_router (
        .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_addr(start_addr),
        .done_pulse(done_pulse), .rd_vld(rd_vld), .rd_addr(rd_addr),
        .rd_status(rd_status), .rd_bank(rd_bank), .start_err(start_err),
        .ready(ready), .bank_busy(bank_busy)
    );

    typedef struct {
        logic       status;
        logic [1:0] bank;
        logic       err;
        logic       rdy;
        logic [3:0] busy;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   m_busy   = 1'b0;
    logic [1:0] m_bank = 2'd0;
    bit   finished = 1'b0;

    function automatic logic [1:0] bank_of(input logic [2:0] code);
        case (code)
            3'd0:             return 2'd0;
            3'd1, 3'd2, 3'd3: return 2'd1;
            3'd4, 3'd5, 3'd6: return 2'd2;
            default:          return 2'd3;
        endcase
    endfunction

    function automatic logic [AW-1:0] mk(input logic [2:0] code, input logic [18:0] low);
        return {code, low};
    endfunction

    task automatic cmp(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected outputs
    task automatic step(input bit sv, input logic [2:0] scode, input bit dn,
                        input bit rv, input logic [2:0] rcode, input string tag);
        exp_t e;
        @(negedge clk);
        start_vld  = sv;
        start_addr = mk(scode, 19'h1A5);
        done_pulse = dn;
        rd_vld     = rv;
        rd_addr    = mk(rcode, 19'h0C3);
        e.bank   = bank_of(rcode);
        e.status = rv && m_busy && (bank_of(rcode) == m_bank);
        e.err    = sv && m_busy;
        e.rdy    = !m_busy;
        e.busy   = m_busy ? (4'b0001 << m_bank) : 4'b0000;
        e.tag    = tag;
        q.push_back(e);
        if (m_busy) begin
            if (dn) m_busy = 1'b0;
        end else if (sv) begin
            m_busy = 1'b1;
            m_bank = bank_of(scode);
        end
    endtask

    // monitor: compare a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "rd_status", {3'b0, rd_status}, {3'b0, e.status});
                cmp(e.tag, "rd_bank",   {2'b0, rd_bank},   {2'b0, e.bank});
                cmp(e.tag, "start_err", {3'b0, start_err}, {3'b0, e.err});
                cmp(e.tag, "ready",     {3'b0, ready},     {3'b0, e.rdy});
                cmp(e.tag, "bank_busy", bank_busy,         e.busy);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R2_reset");
        // R1 decode with no job: every code, all reads array (R6)
        for (int c = 0; c < 8; c++) step(0, 0, 0, 1, 3'(c), "R1_R6_idle_decode");
        // R8 done while idle
        step(0, 0, 1, 1, 3'd0, "R8_idle_done");
        step(0, 0, 0, 1, 3'd5, "R8_after");
        // R3 start in large bank index 1
        step(1, 3'd2, 0, 1, 3'd2, "R3_accept");
        for (int c = 1; c < 4; c++) step(0, 0, 0, 1, 3'(c), "R5_R10_status");
        for (int c = 4; c < 7; c++) step(0, 0, 0, 1, 3'(c), "R10_other_large");
        step(0, 0, 0, 1, 3'd2, "R5_busy_read");
        step(0, 0, 0, 1, 3'd0, "R6_switch_no_wait");
        step(0, 0, 0, 1, 3'd7, "R6_small_bank");
        step(0, 0, 0, 0, 3'd1, "R6_no_read");
        // R4 start while busy
        step(1, 3'd7, 0, 1, 3'd3, "R4_refuse");
        step(0, 0, 0, 1, 3'd3, "R4_bank_kept");
        // R7 done together with a start: refused, then idle
        step(1, 3'd0, 1, 1, 3'd1, "R7_done_with_start");
        step(0, 0, 0, 1, 3'd1, "R7_cleared");
        // R8 done together with a start while idle: accepted
        step(1, 3'd7, 1, 1, 3'd7, "R8_done_start_idle");
        step(0, 0, 0, 1, 3'd7, "R5_small_hi");
        step(0, 0, 0, 1, 3'd6, "R6_next_to_small");
        step(0, 0, 1, 1, 3'd7, "R7_finish");
        step(0, 0, 0, 1, 3'd7, "R7_idle_again");
        // R10 other large bank
        step(1, 3'd5, 0, 0, 3'd0, "R3_accept_large_hi");
        for (int c = 4; c < 7; c++) step(0, 0, 0, 1, 3'(c), "R10_large_hi_status");
        step(0, 0, 0, 1, 3'd3, "R10_large_lo_array");
        step(0, 0, 1, 0, 3'd0, "R7_finish2");
        // R9 small low bank
        step(1, 3'd0, 0, 0, 3'd0, "R3_accept_small_lo");
        step(0, 0, 0, 1, 3'd0, "R9_one_bit");
        step(0, 0, 1, 1, 3'd1, "R7_finish3");
        step(0, 0, 0, 0, 3'd0, "R9_idle");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule